// File: doc/BRIEF.md
# Error Report Capture and Serial Readout

This block keeps the outcome of a configuration-memory error check and makes it available to two readers. A checker upstream presents a 32-bit syndrome, an error kind code and a bit location together with a one-cycle valid strobe. The block packs these into a 67-bit message register. It raises an error flag whenever the stored syndrome is non-zero.

One cycle after the message register takes a new report, the report is copied into a staging register. The staging register feeds two readers. The first is a parallel user-side output for logic in the fabric. The second is a 67-bit serial chain that a test-access controller captures and then shifts out on a single data pin.

The capture of the serial chain uses a one-cycle enable hand-off. A capture request freezes the staging register. On the next edge the chain samples the frozen value. A report that arrives during this window waits, and when the window closes the staging register takes the newest report.

Top module: `err_rpt_top`

## Requirements
- R1: `err_flag_o` is high exactly when the stored syndrome is non-zero. It updates on the same edge that samples `valid_i`.
- R2: The report layout, counted from the least significant bit, is: syndrome in [31:0], location in [62:32], kind in [66:63]. Kind 1 (single bit) and kind 2 (double adjacent) keep `loc_i` as given. Kind 0 (none) stores a location of zero. Kind 3 and above (unlocatable) store a location of all ones.
- R3: `user_rpt_o` shows a new report one edge after the message register has loaded it. In the cycle between those two edges it still shows the previous report.
- R4: After a one-cycle `capture_i` pulse, the serial chain loads the staging register on the following edge. `tdo_o` then presents bit 0 of the report.
- R5: The staging register is not written on the edge that samples `capture_i` or on the following capture edge. A report that arrives in that window is deferred, and the newest report is loaded on the first free edge. Older reports are dropped.
- R6: Each edge with `shift_i` high moves the chain one bit toward `tdo_o`, least significant bit first. Zeros fill in from the top.
- R7: With neither a capture nor `shift_i`, the chain holds its value. A capture load takes priority over `shift_i` on the same edge.
- R8: An active-low reset clears the message, staging and serial registers, so `err_flag_o`, `tdo_o` and `user_rpt_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | New report strobe, one cycle |
| syndrome_i | input | 32 | Computed CRC syndrome |
| kind_i | input | 4 | Error kind code |
| loc_i | input | 31 | Error bit location |
| capture_i | input | 1 | Request to capture staging into the serial chain |
| shift_i | input | 1 | Shift the serial chain by one bit |
| err_flag_o | output | 1 | Syndrome non-zero |
| tdo_o | output | 1 | Serial report data, LSB first |
| user_rpt_o | output | 67 | Parallel copy of the staging register |

## Verification
A staging update and a serial capture can fall due in the same cycle. This happens when a report strobe coincides with a capture request, and again when a second report follows on the capture edge itself.

The bench drives exactly that overlap. It checks that the serial chain shifts out the report that was staged before the request. It also checks that `user_rpt_o` stays frozen through both capture edges and then shows only the newest of the deferred reports.

Random reports are mixed with shift-during-capture and idle gaps. These exercise the load-over-shift priority and the hold behaviour.

// File: rtl/err_rpt_pkg.sv
package err_rpt_pkg;
  parameter int unsigned SYN_W  = 32;
  parameter int unsigned LOC_W  = 31;
  parameter int unsigned KIND_W = 4;
  localparam int unsigned RPT_W = SYN_W + LOC_W + KIND_W;

  localparam logic [KIND_W-1:0] K_NONE   = KIND_W'(0);
  localparam logic [KIND_W-1:0] K_SINGLE = KIND_W'(1);
  localparam logic [KIND_W-1:0] K_DOUBLE = KIND_W'(2);

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [LOC_W-1:0]  loc;
    logic [SYN_W-1:0]  syn;
  } rpt_t;
endpackage

// File: rtl/err_msg_reg.sv
module err_msg_reg
  import err_rpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [LOC_W-1:0]  loc_i,
  output rpt_t              msg_o,
  output logic              flag_o
);
  rpt_t             msg_q;
  logic [LOC_W-1:0] loc_fix;

  always_comb begin
    if (kind_i == K_SINGLE || kind_i == K_DOUBLE) loc_fix = loc_i;
    else if (kind_i == K_NONE)                    loc_fix = '0;
    else                                          loc_fix = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      msg_q <= '0;
    else if (valid_i) msg_q <= '{kind: kind_i, loc: loc_fix, syn: syn_i};
  end

  assign msg_o  = msg_q;
  assign flag_o = |msg_q.syn;

  p_loc_unknown_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_q.kind > K_DOUBLE) |-> (&msg_q.loc));
  p_flag_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(valid_i));
endmodule

// File: rtl/err_stage_ctl.sv
module err_stage_ctl
  import err_rpt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  rpt_t msg_i,
  input  logic capture_i,
  output rpt_t stage_o,
  output logic cap_en_o
);
  rpt_t stage_q;
  logic pend_q, cap_en_q;
  logic block, stage_we;

  // staging frozen from the request edge through the chain's load edge
  assign block    = capture_i | cap_en_q;
  assign stage_we = pend_q & ~block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      pend_q   <= 1'b0;
      cap_en_q <= 1'b0;
    end else begin
      cap_en_q <= capture_i & ~cap_en_q;
      if (stage_we) stage_q <= msg_i;
      if (valid_i)       pend_q <= 1'b1;
      else if (stage_we) pend_q <= 1'b0;
    end
  end

  assign stage_o  = stage_q;
  assign cap_en_o = cap_en_q;

  p_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_q |=> $stable(stage_q));
  p_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !capture_i && !cap_en_q) |=> (stage_q == $past(msg_i)));
endmodule

// File: rtl/err_shift_chain.sv
module err_shift_chain
  import err_rpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RPT_W-1:0] par_i,
  input  logic             shift_i,
  output logic             tdo_o
);
  logic [RPT_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= par_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[RPT_W-1:1]};
  end

  assign tdo_o = sh_q[0];

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sh_q == $past(par_i)));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sh_q));
endmodule

// File: rtl/err_rpt_top.sv
module err_rpt_top
  import err_rpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SYN_W-1:0]  syndrome_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic              capture_i,
  input  logic              shift_i,
  output logic              err_flag_o,
  output logic              tdo_o,
  output logic [RPT_W-1:0]  user_rpt_o
);
  rpt_t msg, stage;
  logic cap_en;

  err_msg_reg u_msg (
    .clk_i, .rst_ni, .valid_i,
    .syn_i(syndrome_i), .kind_i, .loc_i,
    .msg_o(msg), .flag_o(err_flag_o)
  );

  err_stage_ctl u_stage (
    .clk_i, .rst_ni, .valid_i,
    .msg_i(msg), .capture_i,
    .stage_o(stage), .cap_en_o(cap_en)
  );

  err_shift_chain u_chain (
    .clk_i, .rst_ni,
    .load_i(cap_en), .par_i(stage), .shift_i,
    .tdo_o
  );

  assign user_rpt_o = stage;

  p_user_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |=> $stable(user_rpt_o));
endmodule

// File: tb/err_rpt_top_tb.sv
module err_rpt_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] syndrome_i = '0;
  logic [3:0]  kind_i = '0;
  logic [30:0] loc_i = '0;
  logic        capture_i = 1'b0;
  logic        shift_i = 1'b0;
  logic        err_flag_o, tdo_o;
  logic [66:0] user_rpt_o;

  int total = 0;
  int bad = 0;
  logic [66:0] staged = '0;

  always #2.5 clk = ~clk;

  err_rpt_top u_dut (
    .clk_i(clk), .rst_ni, .valid_i, .syndrome_i, .kind_i, .loc_i,
    .capture_i, .shift_i, .err_flag_o, .tdo_o, .user_rpt_o
  );

  function automatic logic [66:0] mk_rpt(logic [31:0] s, logic [3:0] k, logic [30:0] l);
    logic [30:0] lf;
    if (k == 4'd1 || k == 4'd2) lf = l;
    else if (k == 4'd0)         lf = '0;
    else                        lf = '1;
    return {k, lf, s};
  endfunction

  task automatic chk(string req, logic [66:0] act, logic [66:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic post(logic [31:0] s, logic [3:0] k, logic [30:0] l);
    logic [66:0] e;
    e = mk_rpt(s, k, l);
    @(negedge clk);
    valid_i = 1'b1; syndrome_i = s; kind_i = k; loc_i = l;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R1", 67'(err_flag_o), 67'(s != 0));
    chk("R3", user_rpt_o, staged);
    @(negedge clk);
    chk("R2", user_rpt_o, e);
    staged = e;
  endtask

  task automatic shift_out(logic [66:0] e);
    chk("R4", 67'(tdo_o), 67'(e[0]));
    for (int i = 1; i <= 67; i++) begin
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        chk("R7", 67'(tdo_o), 67'(e[i-1]));
      end
      shift_i = 1'b1;
      @(negedge clk);
      shift_i = 1'b0;
      if (i < 67) chk("R6", 67'(tdo_o), 67'(e[i]));
      else        chk("R6", 67'(tdo_o), 67'(0));
    end
  endtask

  task automatic read_out(logic [66:0] e, bit shift_during);
    @(negedge clk);
    capture_i = 1'b1; shift_i = shift_during;
    @(negedge clk);
    capture_i = 1'b0;
    @(negedge clk);
    shift_i = 1'b0;
    if (shift_during) chk("R7", 67'(tdo_o), 67'(e[0]));
    shift_out(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [66:0] a, c;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R8", 67'(err_flag_o), 67'(0));
    chk("R8", 67'(tdo_o), 67'(0));
    chk("R8", user_rpt_o, '0);
    rst_ni = 1'b1;

    // directed kinds
    post(32'hDEAD_BEEF, 4'd1, 31'h0000_1234);
    read_out(staged, 1'b0);
    post(32'h0000_0001, 4'd2, 31'h7000_0005);
    post(32'h0000_0000, 4'd0, 31'h1234_5678);
    chk("R1", 67'(err_flag_o), 67'(0));
    post(32'h8000_0000, 4'd3, 31'h0000_0000);
    read_out(staged, 1'b1);
    post(32'h0F0F_0F0F, 4'd9, 31'h0000_0077);

    // collision: report strobe on capture request, another on capture edge
    a = staged;
    c = mk_rpt(32'hCAFE_0003, 4'd2, 31'h55);
    @(negedge clk);
    capture_i = 1'b1; valid_i = 1'b1;
    syndrome_i = 32'h1111_1111; kind_i = 4'd1; loc_i = 31'h3;
    @(negedge clk);
    capture_i = 1'b0;
    syndrome_i = 32'hCAFE_0003; kind_i = 4'd2; loc_i = 31'h55;
    chk("R5", user_rpt_o, a);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R5", user_rpt_o, a);
    @(negedge clk);
    chk("R5", user_rpt_o, c);
    staged = c;
    shift_out(a);

    // random reports
    for (int n = 0; n < 30; n++) begin
      logic [31:0] s;
      s = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      post(s, 4'($urandom % 6), 31'($urandom));
      if ($urandom % 3 == 0) read_out(staged, 1'($urandom % 2));
    end

    // reset mid-flight
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R8", user_rpt_o, '0);
    chk("R8", 67'(err_flag_o), 67'(0));
    chk("R8", 67'(tdo_o), 67'(0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule